// File: doc/BRIEF.md
# Timer Capture Unit with Edge Prescaler

This block watches one asynchronous input pin and, when a chosen edge event occurs, copies the current count of a free-running timer into a capture register. The pin is first brought into the clock domain through a chain of flip-flops. Its synchronized level is then compared with the previous one to find rising and falling edges. A single 4-bit mode code selects the event. It can be every falling edge, every rising edge, one capture for every fourth rising edge, or one for every sixteenth rising edge. The all-zero code switches the unit off and puts its state back to reset values.

Every capture sets a sticky interrupt flag. Software clears the flag with a write-one pulse and can also force it set. The capture register keeps its value until the next capture. The timer, the interrupt controller and the bus decoding all sit outside the block.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, `mode_o` is 4'b0000, `cap_val` is zero and `flag_o` is low.
- R2: Suppose the pin takes a new level before clock edge k and the selected event occurs. The capture register then loads the `tmr_val` present at edge k+2, and `flag_o` rises at that same edge.
- R3: With mode 4'b0100, every falling edge of the pin causes a capture.
- R4: With mode 4'b0101, every rising edge of the pin causes a capture, and falling edges cause none.
- R5: With mode 4'b0110, a capture occurs on the 4th, 8th, 12th, ... rising edge counted from the last mode write.
- R6: With mode 4'b0111, a capture occurs on the 16th, 32nd, ... rising edge counted from the last mode write.
- R7: While mode is 4'b0000, `cap_val` is forced to zero, `flag_o` is forced low, the prescale count is cleared and no capture occurs.
- R8: Any write to the mode register (`mode_we` high) clears the prescale count. The new code takes effect from the next cycle.
- R9: `flag_o` stays high until a cycle with `flag_clr` high and neither a capture nor `flag_set`. A capture or `flag_set` in the same cycle as `flag_clr` leaves the flag high.
- R10: Codes 4'b0001 to 4'b0011 and 4'b1000 to 4'b1111 cause no capture and leave `cap_val` and `flag_o` unchanged.
- R11: `cap_val` holds its value in every enabled cycle without a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | 1 | Asynchronous event input |
| tmr_val | input | TMR_W | Free-running timer count |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode code to write |
| mode_o | output | 4 | Current mode code |
| cap_val | output | TMR_W | Captured timer value |
| flag_set | input | 1 | Software set of the interrupt flag |
| flag_clr | input | 1 | Write-one-to-clear of the interrupt flag |
| flag_o | output | 1 | Sticky capture interrupt flag |

## Verification
The bench runs a behavioural model that delays the pin by two cycles. It compares the outputs on every clock, so a design with one synchronizer stage too many or too few captures a different timer value. Long pulse trains in the divide-by-4 and divide-by-16 modes catch a counter that wraps one edge early or late. A mode rewrite in the middle of a count would expose a counter that is not cleared on the write. The bench also checks several more cases:
- Flag set and clear in the same cycle, which catches a wrong priority.
- A switch to the off code, which would show state left behind.
- Reserved codes with pin activity, which would reveal a decoder that captures on codes it should ignore.

// File: rtl/edcap_pkg.sv
package edcap_pkg;
   typedef logic [3:0] mode_t;
   localparam mode_t MODE_OFF    = 4'b0000;
   localparam mode_t MODE_FALL   = 4'b0100;
   localparam mode_t MODE_RISE   = 4'b0101;
   localparam mode_t MODE_RISE_A = 4'b0110;
   localparam mode_t MODE_RISE_B = 4'b0111;
endpackage

// File: rtl/edcap_sync.sv
module edcap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] stg;

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= 1'b0;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= 1'b0;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/edcap_evt.sv
module edcap_evt
   import edcap_pkg::*;
#(
   parameter int PRE_A = 4,
   parameter int PRE_B = 16,
   localparam int CW   = $clog2(PRE_B)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lvl,
   input  mode_t         mode,
   input  logic          mode_we,
   output logic          evt,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] LAST_A = CW'(PRE_A - 1);
   localparam logic [CW-1:0] LAST_B = CW'(PRE_B - 1);

   logic prev;
   logic rise, fall;
   logic presc_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   assign rise       = lvl & ~prev;
   assign fall       = ~lvl & prev;
   assign presc_mode = (mode == MODE_RISE_A) || (mode == MODE_RISE_B);

   always_comb begin
      evt = 1'b0;
      case (mode)
         MODE_FALL:   evt = fall;
         MODE_RISE:   evt = rise;
         MODE_RISE_A: evt = rise && (cnt == LAST_A);
         MODE_RISE_B: evt = rise && (cnt == LAST_B);
         default:     evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt <= '0;
      else if (mode == MODE_OFF || mode_we)  cnt <= '0;
      else if (rise && presc_mode)           cnt <= evt ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/edcap_store.sv
module edcap_store #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             off,
   input  logic             evt,
   input  logic [TMR_W-1:0] tmr,
   input  logic             sw_set,
   input  logic             sw_clr,
   output logic [TMR_W-1:0] cap,
   output logic             flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cap <= '0;
      else if (off) cap <= '0;
      else if (evt) cap <= tmr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flag <= 1'b0;
      else if (off)            flag <= 1'b0;
      else if (evt || sw_set)  flag <= 1'b1;
      else if (sw_clr)         flag <= 1'b0;
   end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
   import edcap_pkg::*;
#(
   parameter int TMR_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int PRE_A       = 4,
   parameter int PRE_B       = 16,
   localparam int CW         = $clog2(PRE_B)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_async,
   input  logic [TMR_W-1:0] tmr_val,
   input  logic             mode_we,
   input  logic [3:0]       mode_wdata,
   output logic [3:0]       mode_o,
   output logic [TMR_W-1:0] cap_val,
   input  logic             flag_set,
   input  logic             flag_clr,
   output logic             flag_o
);
   generate
      if (TMR_W < 1) begin : g_bad_w
         $error("edge_capture_unit: TMR_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("edge_capture_unit: SYNC_STAGES must be at least 2");
      end
      if (PRE_A < 2 || PRE_B <= PRE_A) begin : g_bad_pre
         $error("edge_capture_unit: need 2 <= PRE_A < PRE_B");
      end
   endgenerate

   mode_t          mode_q;
   logic           pin_sync;
   logic           cap_evt;
   logic [CW-1:0]  pre_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= MODE_OFF;
      else if (mode_we) mode_q <= mode_wdata;
   end

   edcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_async),
      .q     (pin_sync)
   );

   edcap_evt #(.PRE_A(PRE_A), .PRE_B(PRE_B)) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (pin_sync),
      .mode    (mode_q),
      .mode_we (mode_we),
      .evt     (cap_evt),
      .cnt     (pre_cnt)
   );

   edcap_store #(.TMR_W(TMR_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .off    (mode_q == MODE_OFF),
      .evt    (cap_evt),
      .tmr    (tmr_val),
      .sw_set (flag_set),
      .sw_clr (flag_clr),
      .cap    (cap_val),
      .flag   (flag_o)
   );

   assign mode_o = mode_q;
endmodule

// File: rtl/edcap_chk.sv
module edcap_chk #(
   parameter int TMR_W = 16,
   parameter int CW    = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       mode_q,
   input logic             mode_we,
   input logic [TMR_W-1:0] tmr_val,
   input logic [TMR_W-1:0] cap_val,
   input logic             flag,
   input logic             flag_set,
   input logic             flag_clr,
   input logic             cap_evt,
   input logic [CW-1:0]    pre_cnt
);
   p_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 4'b0000) |=> (cap_val == '0 && !flag));

   p_cap_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (cap_val == $past(tmr_val) && flag));

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_evt && mode_q != 4'b0000) |=> $stable(cap_val));

   p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr && mode_q != 4'b0000) |=> flag);

   p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !flag_set && !cap_evt) |=> !flag);

   p_presc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we |=> (pre_cnt == '0));

   p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |-> (mode_q[3:2] == 2'b01));
endmodule

bind edge_capture_unit edcap_chk #(.TMR_W(TMR_W), .CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_q   (mode_q),
   .mode_we  (mode_we),
   .tmr_val  (tmr_val),
   .cap_val  (cap_val),
   .flag     (flag_o),
   .flag_set (flag_set),
   .flag_clr (flag_clr),
   .cap_evt  (cap_evt),
   .pre_cnt  (pre_cnt)
);

// File: tb/edge_capture_unit_tb.sv
`timescale 1ns/1ps
module edge_capture_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin = 1'b0;
   logic [15:0] tmr = 16'h0000;
   logic        we = 1'b0;
   logic [3:0]  wd = 4'h0;
   logic        fset = 1'b0;
   logic        fclr = 1'b0;
   logic [3:0]  mode_o;
   logic [15:0] cap_val;
   logic        flag_o;

   int    n_tests = 0;
   int    n_fail  = 0;
   string tag = "R1";

   // reference model state
   bit          hist[$];
   int          m_mode, m_cnt;
   logic [15:0] m_cap;
   bit          m_flag;

   always #2.5 clk = ~clk;

   edge_capture_unit u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_async  (pin),
      .tmr_val    (tmr),
      .mode_we    (we),
      .mode_wdata (wd),
      .mode_o     (mode_o),
      .cap_val    (cap_val),
      .flag_set   (fset),
      .flag_clr   (fclr),
      .flag_o     (flag_o)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist = {};
         repeat (3) hist.push_back(1'b0);
         m_mode = 0; m_cnt = 0; m_cap = 16'h0; m_flag = 1'b0;
      end else begin
         bit lv_new, lv_old, rise, fall, evt;
         lv_new = hist[hist.size()-2];
         lv_old = hist[hist.size()-3];
         rise = lv_new && !lv_old;
         fall = !lv_new && lv_old;
         evt = 1'b0;
         if (m_mode == 4)      evt = fall;
         else if (m_mode == 5) evt = rise;
         else if (m_mode == 6) evt = rise && (m_cnt == 3);
         else if (m_mode == 7) evt = rise && (m_cnt == 15);
         if (m_mode == 0) begin
            m_cap = 16'h0; m_flag = 1'b0; m_cnt = 0;
         end else begin
            if (evt) m_cap = tmr;
            if (evt || fset) m_flag = 1'b1;
            else if (fclr)   m_flag = 1'b0;
            if (we) m_cnt = 0;
            else if (rise && (m_mode == 6 || m_mode == 7)) m_cnt = evt ? 0 : m_cnt + 1;
         end
         if (we) m_mode = int'(wd);
         hist.push_back(pin);
         void'(hist.pop_front());
      end
   end

   task automatic check();
      n_tests++;
      if (cap_val !== m_cap || flag_o !== m_flag || int'(mode_o) != m_mode) begin
         n_fail++;
         $display("FAIL %s: cap=%h flag=%b mode=%h expected cap=%h flag=%b mode=%h",
                  tag, cap_val, flag_o, mode_o, m_cap, m_flag, m_mode[3:0]);
      end
   endtask

   task automatic step(input bit p, input bit w = 1'b0, input logic [3:0] d = 4'h0,
                       input bit s = 1'b0, input bit c = 1'b0);
      @(negedge clk);
      check();
      pin = p; we = w; wd = d; fset = s; fclr = c;
      tmr = tmr + 16'h0123;
   endtask

   task automatic hold(input bit p, input int n);
      for (int i = 0; i < n; i++) step(p);
   endtask

   task automatic wmode(input logic [3:0] d);
      step(pin, 1'b1, d);
   endtask

   task automatic pulses(input int n, input int hi, input int lo);
      for (int i = 0; i < n; i++) begin
         hold(1'b1, hi);
         hold(1'b0, lo);
      end
   endtask

   initial begin
      #500000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R1: reset values
      repeat (3) @(negedge clk);
      check();
      rst_n = 1'b1;
      hold(1'b0, 3);

      // R2 R4 R11: single rising edge latency, then held value
      tag = "R2 R4 R11";
      wmode(4'b0101);
      hold(1'b0, 4);
      hold(1'b1, 6);
      hold(1'b0, 6);
      pulses(5, 2, 3);

      // R3: falling edges
      tag = "R3 R11";
      step(1'b0, 1'b0, 4'h0, 1'b0, 1'b1);
      wmode(4'b0100);
      pulses(6, 3, 2);
      hold(1'b0, 4);

      // R5: divide by four
      tag = "R5";
      wmode(4'b0110);
      hold(1'b0, 3);
      pulses(13, 1, 2);
      hold(1'b0, 4);

      // R6: divide by sixteen
      tag = "R6";
      wmode(4'b0111);
      hold(1'b0, 3);
      pulses(35, 1, 1);
      hold(1'b0, 4);

      // R8: rewrite mid count restarts the prescaler
      tag = "R8 R5";
      wmode(4'b0110);
      hold(1'b0, 3);
      pulses(3, 1, 2);
      wmode(4'b0110);
      pulses(5, 1, 2);
      hold(1'b0, 4);

      // R9: flag priority and clearing
      tag = "R9";
      step(1'b0, 1'b0, 4'h0, 1'b0, 1'b1);
      hold(1'b0, 2);
      step(1'b0, 1'b0, 4'h0, 1'b1, 1'b1);
      hold(1'b0, 2);
      step(1'b0, 1'b0, 4'h0, 1'b0, 1'b1);
      hold(1'b0, 2);
      step(1'b0, 1'b0, 4'h0, 1'b1, 1'b0);
      hold(1'b0, 2);
      wmode(4'b0101);
      hold(1'b0, 2);
      step(1'b1);                    // rising edge reaches the detector two cycles later
      step(1'b1);
      step(1'b1, 1'b0, 4'h0, 1'b0, 1'b1); // clear in the capture cycle
      hold(1'b1, 3);
      step(1'b1, 1'b0, 4'h0, 1'b0, 1'b1);
      hold(1'b0, 3);

      // R10: reserved codes ignore the pin
      tag = "R10";
      pulses(2, 2, 2);
      for (int k = 0; k < 16; k++) begin
         if (k == 1 || k == 2 || k == 3 || k >= 8) begin
            wmode(k[3:0]);
            pulses(3, 2, 2);
         end
      end

      // R7: off clears state and blocks captures
      tag = "R7";
      wmode(4'b0101);
      pulses(2, 2, 2);
      wmode(4'b0000);
      pulses(3, 2, 2);
      step(1'b0, 1'b0, 4'h0, 1'b1, 1'b0);
      hold(1'b1, 3);
      wmode(4'b0101);
      hold(1'b1, 5);
      pulses(2, 2, 2);
      hold(1'b0, 3);
      check();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule